// File: doc/BRIEF.md
# Charge-Transfer PWM Sequencer with Comparator Stop

This block drives a switched-capacitor measurement. It produces two complementary pulse trains. The charge output connects a small sense capacitor to the supply. The transfer output dumps that charge into a larger integrating capacitor. A dead band separates the two outputs on both edges, so the two switches are never closed together. Each pulse period moves one packet of charge. The number of periods needed to bring the integrating node up to an external comparator's threshold is inversely proportional to the sense capacitance.

A single trigger starts a measurement. Period, charge-phase length and dead band are taken from run-time inputs and held for the whole measurement. The run stops as soon as the comparator reads high while the transfer output is active. At that point the outputs go quiet, a one-cycle interrupt fires, and the period count is frozen for software to read. The block then asks for the integrating node to be drained through a pull-down until software clears the request. Only after that does it accept a new trigger.

Top module: `cxfer_meter`

## Requirements
- R1: After reset, chg_o, xfer_o, irq_o, drain_o and ovf_o are 0 and count_o is 0.
- R2: A cycle with start_i=1 while idle latches period_i, high_i and dead_i and resets the count and the overflow flag. On the next cycle the run begins at phase 0. The phase counts 0..P-1 and wraps, where P is period_i, taken as 2 when period_i is below 2.
- R3: While running, chg_o is 1 exactly when phase < high. xfer_o is 1 exactly when phase >= high+dead and phase+dead < P. The two outputs are never 1 together.
- R4: A cycle in which cmp_i=1 and xfer_o=1 is a stop. From the next cycle on, chg_o and xfer_o are 0 until a new run starts. cmp_i has no effect while chg_o=1 or while not running.
- R5: irq_o is 1 for exactly the one cycle after a stop, and at no other time.
- R6: count_o increases by one at the end of every running cycle whose phase is 0 (the stop cycle included). It is held unchanged from the stop until the next accepted trigger.
- R7: count_o saturates at 2^NW-1. A further phase-0 cycle leaves it there and sets ovf_o, which holds until the next accepted trigger.
- R8: drain_o is 1 from the cycle after a stop until the cycle after drain_clr_i=1 is seen. drain_clr_i has no effect at any other time.
- R9: start_i is ignored while running or while drain_o=1. The run, the count and the drain state carry on unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Measurement trigger (control bit) |
| period_i | input | CW | Pulse period in clocks |
| high_i | input | CW | Charge-phase length in clocks |
| dead_i | input | CW | Dead band on each edge in clocks |
| cmp_i | input | 1 | Integrator comparator output |
| drain_clr_i | input | 1 | Ends the drain request |
| chg_o | output | 1 | Charge switch drive |
| xfer_o | output | 1 | Transfer switch drive |
| irq_o | output | 1 | One-cycle stop interrupt |
| drain_o | output | 1 | Pull-down drain request |
| count_o | output | NW | Periods counted in this run |
| ovf_o | output | 1 | Count saturated |

## Verification
The bench holds cmp_i high through every charge phase, so a design that forms the stop from the wrong output would end on the first period. It also holds cmp_i high while idle and while draining, so a design that is not gated by the run state would fire spurious interrupts. Runs with zero dead band, a clamped period and a count driven past its limit expose designs with off-by-one window edges, designs that wrap the counter, and designs that lose the overflow flag. Triggers pulsed in the middle of a run and during the drain would, in a design that re-arms, restart the count or cut the drain short. The reference model catches either change on the next cycle.

// File: rtl/cxm_pkg.sv
package cxm_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DRAIN} cxm_state_e;

  function automatic logic [31:0] clamp_period(logic [31:0] p);
    return (p < 32'd2) ? 32'd2 : p;
  endfunction

  function automatic logic phase_charge(logic [31:0] ph, logic [31:0] h);
    return ph < h;
  endfunction

  function automatic logic phase_xfer(logic [31:0] ph, logic [31:0] h,
                                      logic [31:0] d, logic [31:0] p);
    return (ph >= h + d) && (ph + d < p);
  endfunction

  function automatic logic [31:0] phase_step(logic [31:0] ph, logic [31:0] p);
    return (ph + 32'd1 >= p) ? 32'd0 : ph + 32'd1;
  endfunction
endpackage

// File: rtl/cxm_phase_gen.sv
module cxm_phase_gen import cxm_pkg::*; #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic          run_i,
  input  logic [CW-1:0] period_i,
  input  logic [CW-1:0] high_i,
  input  logic [CW-1:0] dead_i,
  output logic          chg_o,
  output logic          xfer_o,
  output logic          cyc_start_o
);
  localparam int PW = CW + 1;

  logic [PW-1:0] per_q;
  logic [CW-1:0] high_q, dead_q, phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      per_q   <= PW'(2);
      high_q  <= '0;
      dead_q  <= '0;
      phase_q <= '0;
    end else if (load_i) begin
      per_q   <= PW'(clamp_period(32'(period_i)));
      high_q  <= high_i;
      dead_q  <= dead_i;
      phase_q <= '0;
    end else if (run_i) begin
      phase_q <= CW'(phase_step(32'(phase_q), 32'(per_q)));
    end
  end

  assign chg_o       = run_i && phase_charge(32'(phase_q), 32'(high_q));
  assign xfer_o      = run_i && phase_xfer(32'(phase_q), 32'(high_q),
                                           32'(dead_q), 32'(per_q));
  assign cyc_start_o = run_i && (phase_q == '0);

  assert_no_overlap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(chg_o && xfer_o));
  assert_phase_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (PW'(phase_q) < per_q));
endmodule

// File: rtl/cxm_cycle_cnt.sv
module cxm_cycle_cnt #(
  parameter int NW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          inc_i,
  output logic [NW-1:0] cnt_o,
  output logic          ovf_o
);
  localparam logic [NW-1:0] CMAX = '1;

  always_ff @(posedge clk) begin
    if (!rst_n || clr_i) begin
      cnt_o <= '0;
      ovf_o <= 1'b0;
    end else if (inc_i) begin
      if (cnt_o == CMAX) ovf_o <= 1'b1;
      else               cnt_o <= cnt_o + 1'b1;
    end
  end

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_o == CMAX && !clr_i) |=> (cnt_o == CMAX));
  assert_hold_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc_i && !clr_i) |=> $stable(cnt_o) && $stable(ovf_o));
endmodule

// File: rtl/cxm_ctrl.sv
module cxm_ctrl import cxm_pkg::*; (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic kill_i,
  input  logic drain_clr_i,
  output logic load_o,
  output logic run_o,
  output logic irq_o,
  output logic drain_o
);
  cxm_state_e st_q;

  assign load_o  = (st_q == ST_IDLE) && start_i;
  assign run_o   = (st_q == ST_RUN);
  assign drain_o = (st_q == ST_DRAIN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      irq_o <= 1'b0;
    end else begin
      irq_o <= 1'b0;
      unique case (st_q)
        ST_IDLE:  if (start_i) st_q <= ST_RUN;
        ST_RUN:   if (kill_i) begin
                    st_q  <= ST_DRAIN;
                    irq_o <= 1'b1;
                  end
        ST_DRAIN: if (drain_clr_i) st_q <= ST_IDLE;
        default:  st_q <= ST_IDLE;
      endcase
    end
  end

  assert_irq_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);
  assert_irq_on_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run_o && kill_i) |=> (irq_o && drain_o));
  assert_drain_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (drain_o && !drain_clr_i) |=> drain_o);
  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (run_o && !kill_i && start_i) |=> run_o);
endmodule

// File: rtl/cxfer_meter.sv
module cxfer_meter import cxm_pkg::*; #(
  parameter int CW = 8,
  parameter int NW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [CW-1:0] period_i,
  input  logic [CW-1:0] high_i,
  input  logic [CW-1:0] dead_i,
  input  logic          cmp_i,
  input  logic          drain_clr_i,
  output logic          chg_o,
  output logic          xfer_o,
  output logic          irq_o,
  output logic          drain_o,
  output logic [NW-1:0] count_o,
  output logic          ovf_o
);
  logic load_w, run_w, kill_w, cyc_start_w;

  assign kill_w = cmp_i && xfer_o;

  cxm_ctrl u_ctrl (
    .clk, .rst_n, .start_i, .kill_i(kill_w), .drain_clr_i,
    .load_o(load_w), .run_o(run_w), .irq_o, .drain_o
  );

  cxm_phase_gen #(.CW(CW)) u_phase (
    .clk, .rst_n, .load_i(load_w), .run_i(run_w),
    .period_i, .high_i, .dead_i,
    .chg_o, .xfer_o, .cyc_start_o(cyc_start_w)
  );

  cxm_cycle_cnt #(.NW(NW)) u_cnt (
    .clk, .rst_n, .clr_i(load_w), .inc_i(cyc_start_w),
    .cnt_o(count_o), .ovf_o
  );

  assert_quiet_after_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    kill_w |=> (!chg_o && !xfer_o));
  assert_quiet_when_drain_R4: assert property (@(posedge clk) disable iff (!rst_n)
    drain_o |-> (!chg_o && !xfer_o));
endmodule

// File: tb/cxfer_meter_bench.sv
`timescale 1ns/1ps
module cxfer_meter_bench;
  localparam int CW = 8;
  localparam int NW = 6;
  localparam int CMAX = (1 << NW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, cmp_i = 1'b1, drain_clr_i = 1'b0;
  logic [CW-1:0] period_i = '0, high_i = '0, dead_i = '0;
  logic chg_o, xfer_o, irq_o, drain_o, ovf_o;
  logic [NW-1:0] count_o;

  int total = 0, bad = 0;

  always #5 clk = ~clk;

  cxfer_meter #(.CW(CW), .NW(NW)) u_cxfer_meter (
    .clk, .rst_n, .start_i, .period_i, .high_i, .dead_i, .cmp_i, .drain_clr_i,
    .chg_o, .xfer_o, .irq_o, .drain_o, .count_o, .ovf_o
  );

  // reference model: 0 idle, 1 running, 2 draining
  int m_st = 0, m_ph = 0, m_p = 2, m_h = 0, m_d = 0;
  int m_cnt = 0, m_per = 0, m_thr = 0, m_irqs = 0;
  bit m_ovf = 0, m_irq = 0;

  function automatic bit exp_chg();
    return (m_st == 1) && (m_ph < m_h);
  endfunction
  function automatic bit exp_xfer();
    return (m_st == 1) && (m_ph >= m_h + m_d) && (m_ph + m_d < m_p);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_ph = 0; m_cnt = 0; m_ovf = 0; m_irq = 0;
    end else begin
      bit stop;
      stop = cmp_i && exp_xfer();
      m_irq = 0;
      if (m_st == 0) begin
        if (start_i) begin
          m_st = 1; m_ph = 0; m_cnt = 0; m_ovf = 0; m_per = 0;
          m_p = (int'(period_i) < 2) ? 2 : int'(period_i);
          m_h = int'(high_i); m_d = int'(dead_i);
        end
      end else if (m_st == 1) begin
        if (m_ph == 0) begin
          m_per++;
          if (m_cnt == CMAX) m_ovf = 1; else m_cnt++;
        end
        m_ph = (m_ph + 1 >= m_p) ? 0 : m_ph + 1;
        if (stop) begin m_st = 2; m_irq = 1; m_irqs++; end
      end else begin
        if (drain_clr_i) m_st = 0;
      end
      // environment: comparator high during charge, low after transfer,
      // high for good once the threshold period count is reached
      #2;
      if (m_st == 1) cmp_i = (m_per >= m_thr) ? 1'b1 : (m_ph < m_h);
      else           cmp_i = 1'b1;
    end
  end

  task automatic check(string req, int act, int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, expv, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      check("R3 chg_o",   int'(chg_o),   int'(exp_chg()));
      check("R3 xfer_o",  int'(xfer_o),  int'(exp_xfer()));
      check("R5 irq_o",   int'(irq_o),   int'(m_irq));
      check("R8 drain_o", int'(drain_o), int'(m_st == 2));
      check("R6 count_o", int'(count_o), m_cnt);
      check("R7 ovf_o",   int'(ovf_o),   int'(m_ovf));
    end
  end

  task automatic edge_drive();
    @(posedge clk); #3;
  endtask

  task automatic measure(int p, int h, int d, int thr, int exp_cnt, bit exp_ovf,
                         bit poke_start);
    int irq0;
    m_thr = thr;
    period_i = CW'(p); high_i = CW'(h); dead_i = CW'(d);
    irq0 = m_irqs;
    edge_drive(); start_i = 1'b1;
    edge_drive(); start_i = 1'b0;
    if (poke_start) begin
      repeat (3) edge_drive();
      start_i = 1'b1;               // R9: ignored mid-run
      edge_drive(); start_i = 1'b0;
    end
    while (!drain_o) edge_drive();
    @(negedge clk);
    check("R6 final count", int'(count_o), exp_cnt);
    check("R7 final ovf", int'(ovf_o), int'(exp_ovf));
    check("R5 one irq per run", m_irqs - irq0, 1);
    // R9/R4: trigger during drain ignored, outputs stay quiet
    edge_drive(); start_i = 1'b1;
    edge_drive(); start_i = 1'b0;
    repeat (2) edge_drive();
    @(negedge clk);
    check("R8 drain held", int'(drain_o), 1);
    check("R4 quiet after stop", int'(chg_o | xfer_o), 0);
    check("R6 count held", int'(count_o), exp_cnt);
    edge_drive(); drain_clr_i = 1'b1;
    edge_drive(); drain_clr_i = 1'b0;
    @(negedge clk);
    check("R8 drain cleared", int'(drain_o), 0);
    repeat (3) edge_drive();
    @(negedge clk);
    check("R4 idle ignores cmp", int'(irq_o | chg_o | xfer_o), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #3 rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset chg/xfer", int'(chg_o | xfer_o), 0);
    check("R1 reset irq/drain", int'(irq_o | drain_o), 0);
    check("R1 reset count", int'(count_o), 0);
    check("R1 reset ovf", int'(ovf_o), 0);
    measure(10, 4, 1, 3, 3, 0, 0);   // R2 R3 basic run
    measure(7, 2, 2, 5, 5, 0, 1);    // R9 start mid-run ignored
    measure(4, 2, 0, 2, 2, 0, 0);    // R3 zero dead band
    measure(0, 1, 0, 4, 4, 0, 0);    // R2 period clamped to 2
    measure(3, 1, 0, 70, CMAX, 1, 0);// R7 saturation
    measure(6, 2, 1, 1, 1, 0, 0);    // R6 stop in first period
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule